// File: doc/BRIEF.md
# Two-Level Exception Dispatcher

This block sits between the interrupt sources of a small processor and its core. Every cycle it looks at thirteen request lines and two reset requests. It decides which of them may interrupt the core and chooses one to serve. It then hands the core a vector address and the class of the accepted request.

Nine sources are maskable and sit at level 0: two external request pins and seven peripheral channels. Each has its own enable bit, and all of them are gated by a 2-bit mask taken from the status register. Four core-internal exceptions sit at level 1 and are never masked. Two reset requests, one from hardware and one from the watchdog, have no level and win over everything else. Their vectors move with an operating-mode input.

The control is a three-state machine. IDLE waits for an eligible request. IDLE→ISSUE captures the vector and level. ISSUE drives the one-cycle strobe. ISSUE→IDLE is taken when `core_ack` is already high, and ISSUE→HOLD when it is not. HOLD keeps the vector and level frozen until the acknowledge arrives, through HOLD→IDLE. The one exception is a pending reset request, which takes the preemption path HOLD→ISSUE.

Top module: `intr_dispatch`

## Requirements
- R1: While `rst_n` is low, and in the first cycles after it is released, `take_exc` is 0, `vec_addr` is 0 and `exc_level` is 0.
- R2: A level-0 source is eligible only when its `src_enable` bit is set and `sr_mask` (bit 1 = I1, bit 0 = I0) equals 2'b01. `src_enable` bit 0 is the external line A and bit 1 is the external line B. Bits 2..8 are peripheral channels 0..6. Mask codes 2'b11, 2'b00 and 2'b10 all block level 0.
- R3: A core exception on `core_exc[k]` is served at every mask code and ignores `src_enable`.
- R4: Among simultaneous eligible requests, the order is hardware reset, then watchdog reset, then level 1, then level 0. Within a level, the lowest source index wins.
- R5: The source index of `core_exc[k]` is k. External A is 4 and external B is 5. Peripheral channel j is 6+j. The vector is `INT_BASE` (default 0x0004) + 2 × index.
- R6: The hardware reset vector is 0x0000 when `mode_hi`=0 and 0xE000 when `mode_hi`=1. The watchdog reset vector is 0x0002 or 0xE002 under the same rule.
- R7: `take_exc` is a one-cycle pulse. It is high in the cycle after the clock edge at which the request was sampled.
- R8: Until `core_ack` is seen high, `vec_addr` and `exc_level` hold their values and no further interrupt is accepted. After the acknowledge, the next request is accepted one edge later.
- R9: While waiting for the acknowledge of an interrupt, a reset request replaces it. The block issues a new strobe carrying the reset vector.
- R10: `exc_level` reads 0 for level 0, 1 for level 1 and 2 for a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| periph_req | input | 7 | Peripheral channel requests, level 0 |
| ext_req | input | 2 | External requests A (bit 0) and B (bit 1), level 0 |
| core_exc | input | 4 | Core-internal exceptions, level 1 |
| hw_rst_req | input | 1 | Hardware reset request |
| wdog_rst_req | input | 1 | Watchdog reset request |
| src_enable | input | 9 | Per-source enable for level-0 sources |
| sr_mask | input | 2 | Status-register mask bits {I1, I0} |
| mode_hi | input | 1 | Operating mode: 1 moves reset vectors to the high page |
| core_ack | input | 1 | Core has taken the vector |
| take_exc | output | 1 | One-cycle strobe: take the exception |
| vec_addr | output | 16 | Vector address to fetch |
| exc_level | output | 2 | Class of accepted request: 0, 1, or 2 for reset |

## Verification
Two functions can meet in the same cycle: arbitration between request classes, and the wait for the acknowledge. The bench provokes the first by raising a reset, a core exception and a maskable request in one cycle, and checks that only the winner's vector appears. It provokes the second by raising a core exception, and later a hardware reset, while an earlier interrupt is still unacknowledged. The core exception must leave the frozen vector untouched until the acknowledge and then be served. The reset must preempt the pending interrupt at once with a fresh strobe.

// File: rtl/intr_dispatch_pkg.sv
package intr_dispatch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HOLD  = 2'd2
    } disp_state_e;

    typedef enum logic [1:0] {
        LVL_MASKABLE = 2'd0,
        LVL_FIXED    = 2'd1,
        LVL_RESET    = 2'd2
    } disp_level_e;

    localparam logic [1:0] MASK_OPEN = 2'b01;

endpackage

// File: rtl/intr_qualify.sv
module intr_qualify
    import intr_dispatch_pkg::*;
#(
    parameter int N_CORE = 4,
    parameter int N_EXT  = 2,
    parameter int N_PER  = 7,
    localparam int N_MASK = N_EXT + N_PER
) (
    input  logic [N_CORE-1:0] core_exc,
    input  logic [N_EXT-1:0]  ext_req,
    input  logic [N_PER-1:0]  periph_req,
    input  logic [N_MASK-1:0] src_enable,
    input  logic [1:0]        sr_mask,
    output logic [N_CORE-1:0] l1_elig,
    output logic [N_MASK-1:0] l0_elig
);
    logic lvl0_admit;

    // reserved codes fall back to the closed setting
    assign lvl0_admit = (sr_mask == MASK_OPEN);
    assign l1_elig    = core_exc;
    assign l0_elig    = ({periph_req, ext_req} & src_enable) & {N_MASK{lvl0_admit}};
endmodule

// File: rtl/intr_select.sv
module intr_select #(
    parameter int N     = 4,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
    assign hit = |req;
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
    import intr_dispatch_pkg::*;
#(
    parameter int          N_CORE   = 4,
    parameter int          N_EXT    = 2,
    parameter int          N_PER    = 7,
    parameter int          ADDR_W   = 16,
    parameter logic [15:0] INT_BASE = 16'h0004,
    localparam int         N_MASK   = N_EXT + N_PER,
    localparam int         N_SRC    = N_CORE + N_MASK,
    localparam int         IDX_W    = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PER-1:0]  periph_req,
    input  logic [N_EXT-1:0]  ext_req,
    input  logic [N_CORE-1:0] core_exc,
    input  logic              hw_rst_req,
    input  logic              wdog_rst_req,
    input  logic [N_MASK-1:0] src_enable,
    input  logic [1:0]        sr_mask,
    input  logic              mode_hi,
    input  logic              core_ack,
    output logic              take_exc,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [1:0]        exc_level
);
    localparam logic [ADDR_W-1:0] HW_LO = ADDR_W'(16'h0000);
    localparam logic [ADDR_W-1:0] HW_HI = ADDR_W'(16'hE000);
    localparam logic [ADDR_W-1:0] WD_LO = ADDR_W'(16'h0002);
    localparam logic [ADDR_W-1:0] WD_HI = ADDR_W'(16'hE002);

    logic [N_CORE-1:0] l1_elig;
    logic [N_MASK-1:0] l0_elig;
    logic              l1_hit, l0_hit;
    logic [IDX_W-1:0]  l1_idx, l0_idx, src_idx;

    disp_state_e state_q, state_d;
    logic [ADDR_W-1:0] vec_d, vec_q;
    disp_level_e       lvl_d, lvl_q;
    logic              any_req, rst_hit, preempt, load;
    logic              busy;

    intr_qualify #(.N_CORE(N_CORE), .N_EXT(N_EXT), .N_PER(N_PER)) u_qual (
        .core_exc   (core_exc),
        .ext_req    (ext_req),
        .periph_req (periph_req),
        .src_enable (src_enable),
        .sr_mask    (sr_mask),
        .l1_elig    (l1_elig),
        .l0_elig    (l0_elig)
    );

    intr_select #(.N(N_CORE), .IDX_W(IDX_W)) u_sel_fixed (
        .req (l1_elig),
        .hit (l1_hit),
        .idx (l1_idx)
    );

    intr_select #(.N(N_MASK), .IDX_W(IDX_W)) u_sel_mask (
        .req (l0_elig),
        .hit (l0_hit),
        .idx (l0_idx)
    );

    // winner and its vector
    assign rst_hit = hw_rst_req | wdog_rst_req;
    assign any_req = rst_hit | l1_hit | l0_hit;
    assign src_idx = l1_hit ? l1_idx : (l0_idx + IDX_W'(N_CORE));

    always_comb begin
        if (hw_rst_req) begin
            vec_d = mode_hi ? HW_HI : HW_LO;
            lvl_d = LVL_RESET;
        end else if (wdog_rst_req) begin
            vec_d = mode_hi ? WD_HI : WD_LO;
            lvl_d = LVL_RESET;
        end else begin
            vec_d = ADDR_W'(INT_BASE) + (ADDR_W'(src_idx) << 1);
            lvl_d = l1_hit ? LVL_FIXED : LVL_MASKABLE;
        end
    end

    assign preempt = rst_hit && (lvl_q != LVL_RESET);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (any_req) state_d = ST_ISSUE;
            ST_ISSUE: state_d = core_ack ? ST_IDLE : ST_HOLD;
            ST_HOLD: begin
                if (preempt)       state_d = ST_ISSUE;
                else if (core_ack) state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    assign load = ((state_q == ST_IDLE) && any_req) ||
                  ((state_q == ST_HOLD) && preempt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            lvl_q <= LVL_MASKABLE;
        end else if (load) begin
            vec_q <= vec_d;
            lvl_q <= lvl_d;
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign take_exc  = (state_q == ST_ISSUE);
    assign vec_addr  = vec_q;
    assign exc_level = lvl_q;
endmodule

// File: rtl/intr_dispatch_chk.sv
module intr_dispatch_chk #(
    parameter int N_CORE = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              take_exc,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [1:0]        exc_level,
    input logic              busy,
    input logic              core_ack,
    input logic              hw_rst_req,
    input logic              wdog_rst_req,
    input logic [N_CORE-1:0] core_exc,
    input logic [1:0]        sr_mask
);
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> !take_exc); // R7

    AST_FROZEN_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !core_ack && !hw_rst_req && !wdog_rst_req) |=> ($stable(vec_addr) && $stable(exc_level))); // R8

    AST_MASK_GATES_LVL0: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_level == 2'd0) |-> ($past(sr_mask) == 2'b01)); // R2

    AST_LVL0_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_level == 2'd0) |-> ($past(core_exc) == '0 && !$past(hw_rst_req) && !$past(wdog_rst_req))); // R4

    AST_RESET_VEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_level == 2'd2) |-> ((vec_addr & ADDR_W'(16'h1FFD)) == '0)); // R6

    AST_LEVEL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |-> (exc_level != 2'd3)); // R10
endmodule

bind intr_dispatch intr_dispatch_chk #(.N_CORE(N_CORE), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_exc     (take_exc),
    .vec_addr     (vec_addr),
    .exc_level    (exc_level),
    .busy         (busy),
    .core_ack     (core_ack),
    .hw_rst_req   (hw_rst_req),
    .wdog_rst_req (wdog_rst_req),
    .core_exc     (core_exc),
    .sr_mask      (sr_mask)
);

// File: tb/tb_intr_dispatch.sv
module tb_intr_dispatch;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  periph_req;
    logic [1:0]  ext_req;
    logic [3:0]  core_exc;
    logic        hw_rst_req, wdog_rst_req;
    logic [8:0]  src_enable;
    logic [1:0]  sr_mask;
    logic        mode_hi, core_ack;
    logic        take_exc;
    logic [15:0] vec_addr;
    logic [1:0]  exc_level;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_dispatch dut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ext_req(ext_req),
        .core_exc(core_exc), .hw_rst_req(hw_rst_req), .wdog_rst_req(wdog_rst_req),
        .src_enable(src_enable), .sr_mask(sr_mask), .mode_hi(mode_hi),
        .core_ack(core_ack), .take_exc(take_exc), .vec_addr(vec_addr),
        .exc_level(exc_level)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_inputs();
        periph_req = '0; ext_req = '0; core_exc = '0;
        hw_rst_req = 1'b0; wdog_rst_req = 1'b0; core_ack = 1'b0;
    endtask

    // inputs already driven at a negedge; expect a strobe after one edge, then acknowledge
    task automatic expect_take(input string req, input int exp_vec, input int exp_lvl);
        @(posedge clk); @(negedge clk);
        chk(take_exc == 1'b1, req, "strobe", take_exc, 1);
        chk(vec_addr == exp_vec[15:0], req, "vector", vec_addr, exp_vec);
        chk(exc_level == exp_lvl[1:0], req, "level", exc_level, exp_lvl);
        core_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        clear_inputs();
        chk(take_exc == 1'b0, "R7", "strobe width", take_exc, 0);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic expect_quiet(input string req, input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk); @(negedge clk);
            chk(take_exc == 1'b0, req, "no strobe", take_exc, 0);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(take_exc == 1'b0, "R1", "reset strobe", take_exc, 0);
        chk(vec_addr == 16'h0000, "R1", "reset vector", vec_addr, 0);
        chk(exc_level == 2'd0, "R1", "reset level", exc_level, 0);
    endtask

    task automatic t_each_maskable();
        sr_mask = 2'b01; src_enable = 9'h1FF;
        for (int k = 0; k < 9; k++) begin
            if (k < 2) ext_req[k] = 1'b1;
            else       periph_req[k-2] = 1'b1;
            expect_take("R5", 16'h0004 + 2 * (4 + k), 0);
        end
    endtask

    task automatic t_mask_blocks();
        src_enable = 9'h001;
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            sr_mask = 2'(m); ext_req = 2'b01;
            expect_quiet("R2", 3);
        end
        sr_mask = 2'b01; src_enable = 9'h000; ext_req = 2'b01;
        expect_quiet("R2", 3);
        src_enable = 9'h001;
        expect_take("R2", 16'h000C, 0);
    endtask

    task automatic t_core_unmasked();
        src_enable = 9'h000;
        for (int k = 0; k < 4; k++) begin
            sr_mask = 2'(k);
            core_exc[k] = 1'b1;
            expect_take("R3", 16'h0004 + 2 * k, 1);
        end
    endtask

    task automatic t_priority();
        sr_mask = 2'b01; src_enable = 9'h1FF;
        core_exc = 4'b1100; ext_req = 2'b01;
        expect_take("R4", 16'h0008, 1);
        periph_req = 7'b0001010; ext_req = 2'b00;
        expect_take("R4", 16'h0012, 0);
        ext_req = 2'b10; periph_req = 7'b0000001;
        expect_take("R4", 16'h000E, 0);
        mode_hi = 1'b0; hw_rst_req = 1'b1; wdog_rst_req = 1'b1; core_exc = 4'b0001;
        expect_take("R4", 16'h0000, 2);
        wdog_rst_req = 1'b1; core_exc = 4'b0001;
        expect_take("R10", 16'h0002, 2);
    endtask

    task automatic t_reset_vectors();
        mode_hi = 1'b1; hw_rst_req = 1'b1;
        expect_take("R6", 16'hE000, 2);
        wdog_rst_req = 1'b1;
        expect_take("R6", 16'hE002, 2);
        mode_hi = 1'b0; wdog_rst_req = 1'b1;
        expect_take("R6", 16'h0002, 2);
        mode_hi = 1'b0;
    endtask

    task automatic t_hold_for_ack();
        sr_mask = 2'b01; src_enable = 9'h1FF;
        ext_req = 2'b10;
        @(posedge clk); @(negedge clk);
        chk(take_exc == 1'b1, "R7", "strobe", take_exc, 1);
        ext_req = 2'b00; core_exc = 4'b0001;
        for (int c = 0; c < 4; c++) begin
            @(posedge clk); @(negedge clk);
            chk(take_exc == 1'b0, "R8", "no new strobe", take_exc, 0);
            chk(vec_addr == 16'h000E, "R8", "held vector", vec_addr, 16'h000E);
            chk(exc_level == 2'd0, "R8", "held level", exc_level, 0);
        end
        core_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        core_ack = 1'b0;
        chk(take_exc == 1'b0, "R8", "idle after ack", take_exc, 0);
        expect_take("R8", 16'h0004, 1);
    endtask

    task automatic t_preempt();
        sr_mask = 2'b01; src_enable = 9'h1FF;
        ext_req = 2'b01;
        @(posedge clk); @(negedge clk);
        ext_req = 2'b00;
        @(posedge clk); @(negedge clk);
        chk(take_exc == 1'b0, "R9", "waiting", take_exc, 0);
        hw_rst_req = 1'b1; mode_hi = 1'b1;
        expect_take("R9", 16'hE000, 2);
        mode_hi = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        clear_inputs();
        src_enable = '0; sr_mask = 2'b11; mode_hi = 1'b0;
        repeat (3) @(posedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(posedge clk);
        t_reset_state();
        t_each_maskable();
        t_mask_blocks();
        t_core_unmasked();
        t_priority();
        t_reset_vectors();
        t_hold_for_ack();
        t_preempt();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule